// File: doc/BRIEF.md
# LPC Host Single-Byte I/O Cycle Controller

This block sits between a processor's register bus and a Low Pin Count bus. It runs one single-byte I/O read or I/O write cycle per command. Software first polls an idle flag. It then loads a command word, a transfer length, a 16-bit I/O address and, for a write, the data byte. Writing the launch bit starts the cycle. The controller drives the start nibble with the frame strobe low, the cycle-type nibble, the address and any write data. It then hands the bus to the target and waits for a ready handshake. Long-wait and short-wait handshakes extend that wait.

When the cycle ends, the controller always raises a completion flag, which software clears by writing 1 to it. A separate success flag reports whether the target answered with ready. A read also returns the byte the target sent. Any of three events aborts a cycle with the success flag clear: an error handshake, a run of clocks with no recognisable handshake, or a command the controller does not support.

Top module: `lpc_io_bridge`

## Requirements
- R1: After reset, the status register (offset 0x04) reads 0x1, with bit 0 idle set and bit 1 success clear. The completion register (0x08) reads 0, the read-data register (0x28) reads 0, `lframe_n` is 1 and `lad_oe` is 0.
- R2: A write with bit 0 set to offset 0x00 launches a cycle only while idle. While a cycle runs, status bit 0 reads 0, and a further launch write starts no second frame.
- R3: A frame begins with one clock of `lframe_n` low while `lad_o` drives 0000. The next clock carries the type nibble: 0010 for an I/O write, 0000 for an I/O read. The next four clocks carry the 16-bit address, most significant nibble first.
- R4: On a write, the byte from bits 7:0 of offset 0x24 follows the address, low nibble first. Two turnaround clocks follow. The controller drives 1111 on the first of them and releases `lad_oe` on the second.
- R5: On a read, two turnaround clocks follow the address. After the ready handshake (0000), the controller samples two nibbles from `lad_i`, low first. These form bits 7:0 of offset 0x28, and bits 31:8 read 0. Two more turnaround clocks end the cycle.
- R6: While waiting for the handshake, the wait codes 0101 and 0110 hold the timeout count. A wait made of such codes may last longer than SYNC_LIMIT clocks and still succeed.
- R7: If SYNC_LIMIT handshake clocks pass with neither a wait code, ready nor error, the cycle aborts. Bit 1 of 0x08 is then set and bit 1 of 0x04 is clear.
- R8: An error handshake (1010) aborts the cycle with bit 1 of 0x08 set and bit 1 of 0x04 clear.
- R9: Bit 1 of offset 0x08 sets when any cycle ends. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R10: Bit 1 of 0x04 sets when a cycle ends with ready and clears at the next launch.
- R11: If the command cycle-type field (bits 2:1 of 0x14) is non-zero, or the length at 0x10 is not 1, a launch ends at once with no frame on the bus. Bit 1 of 0x08 is then set and bit 1 of 0x04 is clear. Bit 0 of 0x14 selects the direction, with 1 meaning write.
- R12: The command (0x14, bits 3:0), length (0x10, 32 bits), address (0x20, bits 15:0) and write-data (0x24, bits 7:0) registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the registers and the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| lad_i | input | 4 | Nibble sampled from the shared bus lines |
| lad_o | output | 4 | Nibble driven onto the shared bus lines |
| lad_oe | output | 1 | Drive enable for `lad_o` |
| lframe_n | output | 1 | Active-low frame strobe |

## Verification
The bench plays the target. It records every nibble the controller drives, so a design that sends the address low nibble first, swaps the write nibbles or sends the wrong type code shows a mismatched captured value. A twelve-clock long wait exceeds the timeout limit. This catches a design that lets wait codes advance the timeout counter, because such a design would abort a good cycle. A silent target, an error handshake and unsupported type or length values check that each abort leaves the success flag clear while the completion flag sets. A launch issued mid-cycle checks that a design ignoring the idle gate does not open a second frame.

// File: rtl/lpc_io_pkg.sv
// Package: shared offsets, handshake codes and sequencer states for the LPC I/O bridge.
package lpc_io_pkg;
    localparam logic [7:0] OFS_LAUNCH = 8'h00;
    localparam logic [7:0] OFS_STATUS = 8'h04;
    localparam logic [7:0] OFS_DONE   = 8'h08;
    localparam logic [7:0] OFS_LEN    = 8'h10;
    localparam logic [7:0] OFS_CMD    = 8'h14;
    localparam logic [7:0] OFS_ADDR   = 8'h20;
    localparam logic [7:0] OFS_WBYTE  = 8'h24;
    localparam logic [7:0] OFS_RBYTE  = 8'h28;

    localparam logic [3:0] HS_READY = 4'b0000;
    localparam logic [3:0] HS_SHORT = 4'b0101;
    localparam logic [3:0] HS_LONG  = 4'b0110;
    localparam logic [3:0] HS_ERROR = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_START, ST_TYPE, ST_ADDR, ST_WDAT,
        ST_TAR1, ST_SYNC, ST_RDAT, ST_TAR2, ST_FIN
    } seq_state_t;
endpackage

// File: rtl/lpc_io_seq.sv
// Sequencer: runs one single-byte I/O cycle on the LPC pins per launch pulse.
// Assumes: go arrives only when busy is low; the address is ADDR_W bits, a multiple of 4.
module lpc_io_seq
    import lpc_io_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int SYNC_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cmd_wr,
    input  logic              cmd_bad,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wbyte,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    output logic              lframe_n,
    output logic              busy,
    output logic              done,
    output logic              ok,
    output logic [7:0]        rbyte
);
    localparam int ADDR_NIB = ADDR_W / 4;
    localparam int IDX_W    = (ADDR_NIB > 2) ? $clog2(ADDR_NIB) : 1;
    localparam int CNT_W    = (SYNC_LIMIT > 2) ? $clog2(SYNC_LIMIT) : 1;

    seq_state_t        state;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  cnt;
    logic              wr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        wbyte_q;
    logic              ok_q;
    logic [IDX_W-1:0]  sel;

    // Purpose: advance the cycle state, latch the command and capture read nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            cnt     <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wbyte_q <= '0;
            ok_q    <= 1'b0;
            rbyte   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    wr_q    <= cmd_wr;
                    addr_q  <= addr;
                    wbyte_q <= wbyte;
                    ok_q    <= 1'b0;
                    idx     <= '0;
                    state   <= cmd_bad ? ST_FIN : ST_START;
                end
                ST_START: state <= ST_TYPE;
                ST_TYPE: begin
                    idx   <= '0;
                    state <= ST_ADDR;
                end
                ST_ADDR: begin
                    if (idx == IDX_W'(ADDR_NIB - 1)) begin
                        idx   <= '0;
                        state <= wr_q ? ST_WDAT : ST_TAR1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_WDAT: begin
                    if (idx == IDX_W'(1)) begin
                        idx   <= '0;
                        state <= ST_TAR1;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_TAR1: begin
                    if (idx == IDX_W'(1)) begin
                        idx   <= '0;
                        cnt   <= '0;
                        state <= ST_SYNC;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_SYNC: begin
                    if (lad_i == HS_READY) begin
                        idx   <= '0;
                        state <= wr_q ? ST_TAR2 : ST_RDAT;
                    end else if (lad_i == HS_ERROR) begin
                        state <= ST_FIN;
                    end else if (lad_i != HS_SHORT && lad_i != HS_LONG) begin
                        if (cnt == CNT_W'(SYNC_LIMIT - 1)) begin
                            state <= ST_FIN;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RDAT: begin
                    if (idx == IDX_W'(1)) begin
                        rbyte[7:4] <= lad_i;
                        idx        <= '0;
                        state      <= ST_TAR2;
                    end else begin
                        rbyte[3:0] <= lad_i;
                        idx        <= idx + 1'b1;
                    end
                end
                ST_TAR2: begin
                    if (idx == IDX_W'(1)) begin
                        ok_q  <= 1'b1;
                        state <= ST_FIN;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: pick the address nibble, most significant first.
    always_comb sel = IDX_W'(ADDR_NIB - 1) - idx;

    // Purpose: decode the pin drive from the current state.
    always_comb begin
        lad_o  = 4'h0;
        lad_oe = 1'b0;
        case (state)
            ST_START: lad_oe = 1'b1;
            ST_TYPE: begin
                lad_oe = 1'b1;
                lad_o  = wr_q ? 4'b0010 : 4'b0000;
            end
            ST_ADDR: begin
                lad_oe = 1'b1;
                lad_o  = addr_q[{sel, 2'b00} +: 4];
            end
            ST_WDAT: begin
                lad_oe = 1'b1;
                lad_o  = (idx == IDX_W'(1)) ? wbyte_q[7:4] : wbyte_q[3:0];
            end
            ST_TAR1: begin
                lad_oe = (idx == '0);
                lad_o  = 4'hF;
            end
            default: ;
        endcase
    end

    assign lframe_n = (state != ST_START);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_FIN);
    assign ok       = ok_q;
endmodule

// File: rtl/lpc_io_regs.sv
// Register slave: holds the command set-up, gates launches on idle and keeps the done/success flags.
// Assumes: single-cycle writes, combinational reads decoded from reg_addr.
module lpc_io_regs
    import lpc_io_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic              ok,
    input  logic [7:0]        rbyte,
    output logic              go,
    output logic              cmd_wr,
    output logic              cmd_bad,
    output logic [ADDR_W-1:0] addr,
    output logic [7:0]        wbyte
);
    logic [3:0]        cmd_q;
    logic [DATA_W-1:0] len_q;
    logic              done_q;
    logic              ok_flag_q;

    assign go      = reg_we && (reg_addr == OFS_LAUNCH) && reg_wdata[0] && !busy;
    assign cmd_wr  = cmd_q[0];
    assign cmd_bad = (cmd_q[2:1] != 2'b00) || (len_q != DATA_W'(1));

    // Purpose: store set-up registers on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
            len_q <= '0;
            addr  <= '0;
            wbyte <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                OFS_CMD:   cmd_q <= reg_wdata[3:0];
                OFS_LEN:   len_q <= reg_wdata;
                OFS_ADDR:  addr  <= reg_wdata[ADDR_W-1:0];
                OFS_WBYTE: wbyte <= reg_wdata[7:0];
                default: ;
            endcase
        end
    end

    // Purpose: set the completion flag at cycle end, clear it on a write of 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done) begin
            done_q <= 1'b1;
        end else if (reg_we && reg_addr == OFS_DONE && reg_wdata[1]) begin
            done_q <= 1'b0;
        end
    end

    // Purpose: success flag clears on launch and takes the cycle result at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_flag_q <= 1'b0;
        end else if (go) begin
            ok_flag_q <= 1'b0;
        end else if (done) begin
            ok_flag_q <= ok;
        end
    end

    // Purpose: read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_STATUS: reg_rdata = DATA_W'({ok_flag_q, !busy});
            OFS_DONE:   reg_rdata = DATA_W'({done_q, 1'b0});
            OFS_LEN:    reg_rdata = len_q;
            OFS_CMD:    reg_rdata = DATA_W'(cmd_q);
            OFS_ADDR:   reg_rdata = DATA_W'(addr);
            OFS_WBYTE:  reg_rdata = DATA_W'(wbyte);
            OFS_RBYTE:  reg_rdata = DATA_W'(rbyte);
            default: ;
        endcase
    end
endmodule

// File: rtl/lpc_io_bridge.sv
// Top: register-programmed LPC host that runs single-byte I/O reads and writes.
// Assumes: one outstanding cycle; software polls the idle and completion flags.
module lpc_io_bridge #(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    parameter int SYNC_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    output logic              lframe_n
);
    logic              go;
    logic              busy;
    logic              done;
    logic              ok;
    logic              cmd_wr;
    logic              cmd_bad;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wbyte;
    logic [7:0]        rbyte;

    lpc_io_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .done(done),
        .ok(ok), .rbyte(rbyte), .go(go), .cmd_wr(cmd_wr), .cmd_bad(cmd_bad),
        .addr(addr), .wbyte(wbyte)
    );

    lpc_io_seq #(.ADDR_W(ADDR_W), .SYNC_LIMIT(SYNC_LIMIT)) u_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .cmd_wr(cmd_wr), .cmd_bad(cmd_bad),
        .addr(addr), .wbyte(wbyte), .lad_i(lad_i), .lad_o(lad_o), .lad_oe(lad_oe),
        .lframe_n(lframe_n), .busy(busy), .done(done), .ok(ok), .rbyte(rbyte)
    );
endmodule

// File: rtl/lpc_io_bridge_chk.sv
// Checker: temporal rules between the register slave, the sequencer and the pins.
module lpc_io_bridge_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       go,
    input logic       busy,
    input logic       done,
    input logic       lframe_n,
    input logic       lad_oe,
    input logic [3:0] lad_o
);
    assert_launch_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);
    assert_launch_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);
    assert_frame_one_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> lframe_n);
    assert_frame_start_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |-> (lad_oe && lad_o == 4'b0000));
    assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (lframe_n && !lad_oe));
    assert_end_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

bind lpc_io_bridge lpc_io_bridge_chk u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done),
    .lframe_n(lframe_n), .lad_oe(lad_oe), .lad_o(lad_o)
);

// File: tb/sim_lpc_io_bridge.sv
module sim_lpc_io_bridge;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  lad_i = 4'hF;
    logic [3:0]  lad_o;
    logic        lad_oe;
    logic        lframe_n;

    int nchk = 0;
    int nerr = 0;

    // target model settings and captures
    int         t_wait = 0;
    logic [3:0] t_wcode = 4'b0101;
    logic [3:0] t_final = 4'b0000;
    logic [7:0] t_rbyte = 8'h00;
    int         frames = 0;
    logic [3:0] cap_type = '0;
    logic [15:0] cap_addr = '0;
    logic [7:0] cap_wd = '0;
    logic       tar_rel = 1'b0;
    int         idx = 0;
    logic       is_wr = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    lpc_io_bridge u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lad_i(lad_i),
        .lad_o(lad_o), .lad_oe(lad_oe), .lframe_n(lframe_n)
    );

    // target model: records host nibbles and answers the handshake
    always @(negedge clk) begin
        if (rst_n && !lframe_n) begin
            frames = frames + 1;
            idx = 1;
        end else if (idx > 0) begin
            int s;
            int rel;
            if (idx == 1) begin
                cap_type = lad_o;
                is_wr = (lad_o == 4'b0010);
            end else if (idx <= 5) begin
                cap_addr = {cap_addr[11:0], lad_o};
            end else if (is_wr && idx == 6) begin
                cap_wd[3:0] = lad_o;
            end else if (is_wr && idx == 7) begin
                cap_wd[7:4] = lad_o;
            end
            s = is_wr ? 10 : 8;
            if (idx == s - 1) tar_rel = !lad_oe;
            if (idx >= s) begin
                rel = idx - s;
                if (rel < t_wait) lad_i = t_wcode;
                else if (rel == t_wait) lad_i = t_final;
                else if (t_final == 4'b0000 && !is_wr && rel == t_wait + 1) lad_i = t_rbyte[3:0];
                else if (t_final == 4'b0000 && !is_wr && rel == t_wait + 2) lad_i = t_rbyte[7:4];
                else begin
                    lad_i = 4'hF;
                    if (rel > t_wait + 4) idx = -1;
                end
            end
            idx = idx + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] v;
        for (int i = 0; i < 300; i++) begin
            reg_rd(8'h08, v);
            if (v[1]) return;
        end
        chk({tag, " completion flag never set"}, 0, 1);
    endtask

    task automatic launch(input logic [3:0] cmd, input logic [31:0] len,
                          input logic [15:0] a, input logic [7:0] d);
        reg_wr(8'h08, 32'h2);
        reg_wr(8'h14, {28'h0, cmd});
        reg_wr(8'h10, len);
        reg_wr(8'h24, {24'h0, d});
        reg_wr(8'h20, {16'h0, a});
        reg_wr(8'h00, 32'h1);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        reg_rd(8'h04, v); chk("R1 status", v, 32'h1);
        reg_rd(8'h08, v); chk("R1 completion", v, 32'h0);
        reg_rd(8'h28, v); chk("R1 read data", v, 32'h0);
        chk("R1 pins", {30'h0, lframe_n, lad_oe}, 32'h2);
    endtask

    task automatic t_write;
        logic [31:0] v;
        int f0 = frames;
        t_wait = 2; t_wcode = 4'b0101; t_final = 4'b0000;
        launch(4'b1001, 1, 16'h02F8, 8'hA5);
        wait_done("R4");
        chk("R2 one frame", frames - f0, 1);
        chk("R3 write type nibble", cap_type, 32'h2);
        chk("R3 address order", cap_addr, 32'h02F8);
        chk("R4 write byte", cap_wd, 32'hA5);
        chk("R4 released on second turnaround", tar_rel, 1);
        reg_rd(8'h04, v); chk("R10 success", v, 32'h3);
        reg_wr(8'h08, 32'h0);
        reg_rd(8'h08, v); chk("R9 write 0 keeps flag", v, 32'h2);
        reg_wr(8'h08, 32'h2);
        reg_rd(8'h08, v); chk("R9 write 1 clears", v, 32'h0);
    endtask

    task automatic t_read_long;
        logic [31:0] v;
        t_wait = 12; t_wcode = 4'b0110; t_final = 4'b0000; t_rbyte = 8'h3C;
        launch(4'b1000, 1, 16'h03FD, 8'h00);
        wait_done("R5");
        chk("R3 read type nibble", cap_type, 32'h0);
        chk("R3 read address", cap_addr, 32'h03FD);
        chk("R5 released after address", tar_rel, 1);
        reg_rd(8'h28, v); chk("R5 read byte", v, 32'h3C);
        reg_rd(8'h04, v); chk("R6 long wait succeeds", v, 32'h3);
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        t_wait = 0; t_final = 4'hF;
        launch(4'b1000, 1, 16'h0060, 8'h00);
        reg_rd(8'h04, v); chk("R10 success cleared at launch", v[1], 0);
        wait_done("R7");
        reg_rd(8'h04, v); chk("R7 timeout fails", v, 32'h1);
        reg_rd(8'h08, v); chk("R7 completion set", v, 32'h2);
        reg_rd(8'h28, v); chk("R7 read byte kept", v, 32'h3C);
    endtask

    task automatic t_error;
        logic [31:0] v;
        t_wait = 1; t_wcode = 4'b0101; t_final = 4'b1010;
        launch(4'b0001, 1, 16'h0080, 8'h11);
        wait_done("R8");
        reg_rd(8'h04, v); chk("R8 error fails", v, 32'h1);
        reg_rd(8'h08, v); chk("R8 completion set", v, 32'h2);
    endtask

    task automatic t_unsupported;
        logic [31:0] v;
        int f0 = frames;
        launch(4'b1011, 1, 16'h0010, 8'h22);
        wait_done("R11");
        reg_rd(8'h04, v); chk("R11 bad type fails", v, 32'h1);
        launch(4'b1001, 2, 16'h0010, 8'h22);
        wait_done("R11");
        reg_rd(8'h04, v); chk("R11 bad length fails", v, 32'h1);
        chk("R11 no frame", frames - f0, 0);
    endtask

    task automatic t_busy_launch;
        logic [31:0] v;
        int f0 = frames;
        t_wait = 20; t_wcode = 4'b0110; t_final = 4'b0000;
        launch(4'b0001, 1, 16'h0100, 8'h5A);
        reg_rd(8'h04, v); chk("R2 busy reads not idle", v[0], 0);
        reg_wr(8'h00, 32'h1);
        wait_done("R2");
        repeat (6) @(negedge clk);
        chk("R2 launch while busy ignored", frames - f0, 1);
        chk("R2 first cycle data", cap_wd, 32'h5A);
    endtask

    task automatic t_readback;
        logic [31:0] v;
        reg_wr(8'h14, 32'h0000_000D); reg_rd(8'h14, v); chk("R12 command", v, 32'hD);
        reg_wr(8'h10, 32'hCAFE_0001); reg_rd(8'h10, v); chk("R12 length", v, 32'hCAFE_0001);
        reg_wr(8'h20, 32'hFFFF_1234); reg_rd(8'h20, v); chk("R12 address", v, 32'h1234);
        reg_wr(8'h24, 32'hFFFF_FF77); reg_rd(8'h24, v); chk("R12 write data", v, 32'h77);
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_write;
        t_read_long;
        t_timeout;
        t_error;
        t_unsupported;
        t_busy_launch;
        t_readback;
        finish_run;
    end

    initial begin
        #(CLK_P * 100000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        finish_run;
    end
endmodule